// File: doc/BRIEF.md
# Packetised SPI Master Timing Engine

This block is a full-duplex SPI master that moves a run of bytes split into packets. A run is a packet byte count repeated a programmed number of times. Every timing interval is a programmable count of reference clock cycles:

- the SCK high time;
- the SCK low time;
- the chip-select setup time before the first clock of a packet;
- the chip-select hold time after its last clock;
- the chip-select idle gap between packets.

Clock polarity, clock phase, the bit order of each direction and the chip-select polarity are plain configuration inputs. They are sampled live and must stay stable while a run is in progress.

Transmit bytes arrive on a valid/ready stream and are pulled one at a time, as each byte slot begins. Received bytes leave on a valid-only stream, one pulse per byte. A start pulse launches a run and a one-cycle done pulse ends it. With pause enabled the engine stops after a run with chip select still asserted, and a resume pulse launches the next run without releasing it. An abort pulse returns the engine to idle from any state.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset the chip select is inactive (the inverse of `cs_active_high`), `spi_sck` equals `cpol`, `spi_mosi` is 0, and `tx_ready`, `rx_valid` and `done` are all 0.
- R2: On the cycle after a start pulse is sampled in idle, chip select goes active. It stays active with SCK at its idle level for `cs_setup_cyc`+1 cycles before the first byte slot begins.
- R3: Each bit spends `sck_hi_cyc`+1 cycles with SCK high and `sck_lo_cyc`+1 cycles with SCK low. The idle level equals `cpol`, and the half at the idle level comes first in every bit.
- R4: With `cpha`=0, MOSI takes each bit at the start of that bit, and MISO is sampled on the clock edge that ends the bit's first half. With `cpha`=1, MOSI changes on the edge that ends the first half, and MISO is sampled on the edge that ends the second half.
- R5: `tx_lsb_first`=1 sends bit 0 of each byte first, otherwise bit 7 first. `rx_lsb_first`=1 places the first received bit at bit 0 of `rx_data`, otherwise at bit 7.
- R6: A run carries `pkt_count_m1`+1 packets of `pkt_bytes_m1`+1 bytes each. Between packets, chip select is inactive for `cs_gap_cyc`+1 cycles and is then reasserted with a fresh setup period.
- R7: After the last bit of each packet, chip select stays active for `cs_hold_cyc`+1 cycles. `done` pulses for exactly one cycle, on the cycle after the hold of the last packet ends.
- R8: Each byte slot opens with a fetch phase in which `tx_ready` is 1 and SCK holds its idle level. The fetch phase lasts until `tx_valid` is seen, so it takes (wait cycles + 1) cycles, and exactly one byte is taken per slot.
- R9: `rx_valid` pulses for one cycle, on the cycle after the final SCK edge of each byte, with the assembled byte on `rx_data`.
- R10: `cs_active_high`=1 makes the asserted chip-select level 1; `cs_active_high`=0 makes it 0.
- R11: With `pause_en`=1, chip select stays active after `done`. A later `resume` pulse starts a new run at its setup period without chip select ever going inactive.
- R12: A pulse on `abort` in any state makes the next cycle show inactive chip select, SCK at its idle level, MOSI 0 and `tx_ready` 0.
- R13: A start pulse that arrives while a run is in progress has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_hi_cyc | input | SCK_W | SCK high time minus one, in cycles |
| sck_lo_cyc | input | SCK_W | SCK low time minus one, in cycles |
| cs_setup_cyc | input | CS_W | Chip-select setup time minus one |
| cs_hold_cyc | input | CS_W | Chip-select hold time minus one |
| cs_gap_cyc | input | GAP_W | Inter-packet deselect time minus one |
| pkt_bytes_m1 | input | LEN_W | Bytes per packet minus one |
| pkt_count_m1 | input | LOOP_W | Packets per run minus one |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| tx_lsb_first | input | 1 | Transmit bit order |
| rx_lsb_first | input | 1 | Receive bit order |
| cs_active_high | input | 1 | Asserted level of chip select |
| pause_en | input | 1 | Keep chip select asserted after a run |
| start | input | 1 | Launch a run from idle |
| resume | input | 1 | Launch a run from the paused state |
| abort | input | 1 | Return to idle immediately |
| tx_data | input | DATA_W | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes a byte this cycle if valid |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| done | output | 1 | One-cycle end-of-run pulse |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 1 | Chip select |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest states to reach from the ports are the inter-packet gap that follows a hold, the resume from pause with chip select held across two runs, and a fetch phase stretched by a late transmit byte. The bench computes from the configuration alone the full expected waveform of each run as a queue of per-cycle entries. It drives a slave that answers on real SCK edges and a transmit source that withholds chosen bytes for a set number of cycles. Mid-run start and abort pulses are injected at chosen entries of the queue.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FETCH,
    ST_BITS,
    ST_HOLD,
    ST_GAP,
    ST_PAUSE
  } seq_state_e;
endpackage

// File: rtl/spi_pkt_delay.sv
// Down-counter for one timing phase: loaded on phase entry, expired at zero.
module spi_pkt_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_pkt_shift.sv
// Transmit and receive shift registers with per-direction bit order.
module spi_pkt_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_lsb_first,
  input  logic              advance,
  input  logic              sample,
  input  logic              miso,
  input  logic              rx_lsb_first,
  output logic              tx_head,
  output logic              tx_next,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr_q;
  logic [DATA_W-1:0] rx_sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr_q <= '0;
    end else if (load) begin
      tx_sr_q <= load_data;
    end else if (advance) begin
      if (tx_lsb_first) tx_sr_q <= {1'b0, tx_sr_q[DATA_W-1:1]};
      else              tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr_q <= '0;
    end else if (sample) begin
      if (rx_lsb_first) rx_sr_q <= {miso, rx_sr_q[DATA_W-1:1]};
      else              rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
    end
  end

  assign tx_head = tx_lsb_first ? tx_sr_q[0] : tx_sr_q[DATA_W-1];
  assign tx_next = tx_lsb_first ? tx_sr_q[1] : tx_sr_q[DATA_W-2];
  assign rx_word = rx_sr_q;
endmodule

// File: rtl/spi_pkt_seq.sv
// Phase sequencer: setup, byte fetch, bit halves, hold, gap, pause.
module spi_pkt_seq
  import spi_pkt_pkg::*;
#(
  parameter int SCK_W  = 8,
  parameter int CS_W   = 16,
  parameter int GAP_W  = 8,
  parameter int LEN_W  = 16,
  parameter int LOOP_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SCK_W-1:0]  sck_hi_cyc,
  input  logic [SCK_W-1:0]  sck_lo_cyc,
  input  logic [CS_W-1:0]   cs_setup_cyc,
  input  logic [CS_W-1:0]   cs_hold_cyc,
  input  logic [GAP_W-1:0]  cs_gap_cyc,
  input  logic [LEN_W-1:0]  pkt_bytes_m1,
  input  logic [LOOP_W-1:0] pkt_count_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tx_lsb_first,
  input  logic              cs_active_high,
  input  logic              pause_en,
  input  logic              start,
  input  logic              resume,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_head,
  input  logic              tx_next,
  input  logic              cnt_expired,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              sh_load,
  output logic              sh_advance,
  output logic              sh_sample,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_cs
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  seq_state_e        state_q;
  logic              half_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  bytes_left_q;
  logic [LOOP_W-1:0] pkts_left_q;
  logic              cs_q, sck_q, mosi_q, done_q, rxv_q;

  logic [CNT_W-1:0] first_half, second_half;
  logic             first_bit;
  logic             half_end;

  assign first_half  = cpol ? CNT_W'(sck_hi_cyc) : CNT_W'(sck_lo_cyc);
  assign second_half = cpol ? CNT_W'(sck_lo_cyc) : CNT_W'(sck_hi_cyc);
  assign first_bit   = tx_lsb_first ? tx_data[0] : tx_data[DATA_W-1];
  assign half_end    = (state_q == ST_BITS) && cnt_expired;

  // Counter reload for the phase being entered
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        cnt_load = 1'b1; cnt_val = CNT_W'(cs_setup_cyc);
      end
      ST_PAUSE: if (resume) begin
        cnt_load = 1'b1; cnt_val = CNT_W'(cs_setup_cyc);
      end
      ST_GAP: if (cnt_expired) begin
        cnt_load = 1'b1; cnt_val = CNT_W'(cs_setup_cyc);
      end
      ST_FETCH: if (tx_valid) begin
        cnt_load = 1'b1; cnt_val = first_half;
      end
      ST_BITS: if (cnt_expired) begin
        if (!half_q) begin
          cnt_load = 1'b1; cnt_val = second_half;
        end else if (bit_q != LAST_BIT) begin
          cnt_load = 1'b1; cnt_val = first_half;
        end else if (bytes_left_q == '0) begin
          cnt_load = 1'b1; cnt_val = CNT_W'(cs_hold_cyc);
        end
      end
      ST_HOLD: if (cnt_expired && pkts_left_q != '0) begin
        cnt_load = 1'b1; cnt_val = CNT_W'(cs_gap_cyc);
      end
      default: ;
    endcase
  end

  assign sh_load    = (state_q == ST_FETCH) && tx_valid;
  assign sh_advance = half_end && half_q;
  assign sh_sample  = half_end && (half_q == cpha);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state_q      <= ST_IDLE;
      half_q       <= 1'b0;
      bit_q        <= '0;
      bytes_left_q <= '0;
      pkts_left_q  <= '0;
      cs_q         <= ~cs_active_high;
      sck_q        <= cpol;
      mosi_q       <= 1'b0;
      done_q       <= 1'b0;
      rxv_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cs_q  <= ~cs_active_high;
          sck_q <= cpol;
          if (start) begin
            state_q      <= ST_SETUP;
            cs_q         <= cs_active_high;
            bytes_left_q <= pkt_bytes_m1;
            pkts_left_q  <= pkt_count_m1;
          end
        end
        ST_PAUSE: begin
          sck_q <= cpol;
          if (resume) begin
            state_q      <= ST_SETUP;
            bytes_left_q <= pkt_bytes_m1;
            pkts_left_q  <= pkt_count_m1;
          end
        end
        ST_SETUP: if (cnt_expired) state_q <= ST_FETCH;
        ST_FETCH: if (tx_valid) begin
          state_q <= ST_BITS;
          half_q  <= 1'b0;
          bit_q   <= '0;
          if (!cpha) mosi_q <= first_bit;
        end
        ST_BITS: if (cnt_expired) begin
          if (!half_q) begin
            half_q <= 1'b1;
            sck_q  <= ~cpol;
            if (cpha) mosi_q <= tx_head;
          end else begin
            half_q <= 1'b0;
            sck_q  <= cpol;
            if (bit_q != LAST_BIT) begin
              bit_q <= bit_q + 1'b1;
              if (!cpha) mosi_q <= tx_next;
            end else begin
              rxv_q <= 1'b1;
              if (bytes_left_q != '0) begin
                bytes_left_q <= bytes_left_q - 1'b1;
                state_q      <= ST_FETCH;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
        end
        ST_HOLD: if (cnt_expired) begin
          if (pkts_left_q != '0) begin
            pkts_left_q  <= pkts_left_q - 1'b1;
            bytes_left_q <= pkt_bytes_m1;
            state_q      <= ST_GAP;
            cs_q         <= ~cs_active_high;
          end else begin
            done_q <= 1'b1;
            if (pause_en) begin
              state_q <= ST_PAUSE;
            end else begin
              state_q <= ST_IDLE;
              cs_q    <= ~cs_active_high;
            end
          end
        end
        ST_GAP: if (cnt_expired) begin
          state_q <= ST_SETUP;
          cs_q    <= cs_active_high;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready = (state_q == ST_FETCH);
  assign rx_valid = rxv_q;
  assign done     = done_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = mosi_q;
  assign spi_cs   = cs_q;
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master #(
  parameter int SCK_W  = 8,
  parameter int CS_W   = 16,
  parameter int GAP_W  = 8,
  parameter int LEN_W  = 16,
  parameter int LOOP_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SCK_W-1:0]  sck_hi_cyc,
  input  logic [SCK_W-1:0]  sck_lo_cyc,
  input  logic [CS_W-1:0]   cs_setup_cyc,
  input  logic [CS_W-1:0]   cs_hold_cyc,
  input  logic [GAP_W-1:0]  cs_gap_cyc,
  input  logic [LEN_W-1:0]  pkt_bytes_m1,
  input  logic [LOOP_W-1:0] pkt_count_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tx_lsb_first,
  input  logic              rx_lsb_first,
  input  logic              cs_active_high,
  input  logic              pause_en,
  input  logic              start,
  input  logic              resume,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_cs,
  input  logic              spi_miso
);
  localparam int W_A   = (SCK_W > GAP_W) ? SCK_W : GAP_W;
  localparam int CNT_W = (CS_W > W_A) ? CS_W : W_A;

  logic             cnt_load, cnt_expired;
  logic [CNT_W-1:0] cnt_val;
  logic             sh_load, sh_advance, sh_sample, tx_head, tx_next;

  spi_pkt_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .expired(cnt_expired)
  );

  spi_pkt_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_data(tx_data),
    .tx_lsb_first(tx_lsb_first), .advance(sh_advance), .sample(sh_sample),
    .miso(spi_miso), .rx_lsb_first(rx_lsb_first),
    .tx_head(tx_head), .tx_next(tx_next), .rx_word(rx_data)
  );

  spi_pkt_seq #(
    .SCK_W(SCK_W), .CS_W(CS_W), .GAP_W(GAP_W), .LEN_W(LEN_W),
    .LOOP_W(LOOP_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .sck_hi_cyc(sck_hi_cyc), .sck_lo_cyc(sck_lo_cyc),
    .cs_setup_cyc(cs_setup_cyc), .cs_hold_cyc(cs_hold_cyc), .cs_gap_cyc(cs_gap_cyc),
    .pkt_bytes_m1(pkt_bytes_m1), .pkt_count_m1(pkt_count_m1),
    .cpol(cpol), .cpha(cpha), .tx_lsb_first(tx_lsb_first),
    .cs_active_high(cs_active_high), .pause_en(pause_en),
    .start(start), .resume(resume), .abort(abort),
    .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_head(tx_head), .tx_next(tx_next), .cnt_expired(cnt_expired),
    .cnt_load(cnt_load), .cnt_val(cnt_val),
    .sh_load(sh_load), .sh_advance(sh_advance), .sh_sample(sh_sample),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .done(done),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs(spi_cs)
  );
endmodule

// File: rtl/spi_pkt_master_chk.sv
module spi_pkt_master_chk (
  input logic clk,
  input logic rst,
  input logic abort,
  input logic cs_active_high,
  input logic cpol,
  input logic tx_ready,
  input logic rx_valid,
  input logic done,
  input logic spi_cs,
  input logic spi_sck
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  rxv_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9
  rxv_selected_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (spi_cs == cs_active_high));

  // R8
  fetch_sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (spi_sck == cpol));

  // R7
  done_not_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !tx_ready);

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (spi_cs != cs_active_high) && !tx_ready && !done);
endmodule

bind spi_pkt_master spi_pkt_master_chk u_chk (
  .clk(clk), .rst(rst), .abort(abort), .cs_active_high(cs_active_high),
  .cpol(cpol), .tx_ready(tx_ready), .rx_valid(rx_valid), .done(done),
  .spi_cs(spi_cs), .spi_sck(spi_sck)
);

// File: tb/tb_spi_pkt_master.sv
`timescale 1ns/1ps
module tb_spi_pkt_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0]  sck_hi_cyc = 8'd1, sck_lo_cyc = 8'd1;
  logic [15:0] cs_setup_cyc = 16'd1, cs_hold_cyc = 16'd1;
  logic [7:0]  cs_gap_cyc = 8'd1;
  logic [15:0] pkt_bytes_m1 = 16'd0;
  logic [7:0]  pkt_count_m1 = 8'd0;
  logic cpol = 1'b0, cpha = 1'b0, tx_lsb_first = 1'b0, rx_lsb_first = 1'b0;
  logic cs_active_high = 1'b0, pause_en = 1'b0;
  logic start = 1'b0, resume = 1'b0, abort = 1'b0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, done, spi_sck, spi_mosi, spi_cs, spi_miso;

  spi_pkt_master dut (
    .clk(clk), .rst(rst), .sck_hi_cyc(sck_hi_cyc), .sck_lo_cyc(sck_lo_cyc),
    .cs_setup_cyc(cs_setup_cyc), .cs_hold_cyc(cs_hold_cyc), .cs_gap_cyc(cs_gap_cyc),
    .pkt_bytes_m1(pkt_bytes_m1), .pkt_count_m1(pkt_count_m1),
    .cpol(cpol), .cpha(cpha), .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first),
    .cs_active_high(cs_active_high), .pause_en(pause_en),
    .start(start), .resume(resume), .abort(abort),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .done(done),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0;

  function automatic logic [7:0] txb(int k);
    return 8'((k * 53 + 17) & 255);
  endfunction
  function automatic logic [7:0] sbb(int k);
    return 8'(((k * 29 + 101) & 255) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // Transmit source: byte k is withheld for stall_of(k) fetch cycles
  logic stall_on = 1'b0;
  int txi = 0, wait_cnt = 0;
  function automatic int stall_of(int k);
    return stall_on ? (k % 3) : 0;
  endfunction
  assign tx_data  = txb(txi);
  assign tx_valid = (wait_cnt >= stall_of(txi));
  always @(posedge clk) begin
    if (tx_ready && tx_valid) begin txi <= txi + 1; wait_cnt <= 0; end
    else if (tx_ready) wait_cnt <= wait_cnt + 1;
  end

  // Slave: sends sbb bytes MSB first, moving on real SCK edges
  int gbi = 0;
  logic prev_sck = 1'b0, mbit = 1'b0;
  function automatic logic bitof(int g);
    logic [7:0] b = sbb(g / 8);
    return b[7 - (g % 8)];
  endfunction
  always @(negedge clk) begin
    if (spi_cs != cs_active_high) gbi = ((gbi + 7) / 8) * 8;
    else if (!cpha && prev_sck != cpol && spi_sck == cpol) gbi = gbi + 1;
    else if (cpha && prev_sck == cpol && spi_sck != cpol) begin mbit = bitof(gbi); gbi = gbi + 1; end
    prev_sck = spi_sck;
  end
  assign spi_miso = cpha ? mbit : bitof(gbi);

  // Reference waveform
  typedef struct packed {
    logic cs, sck, mosi, txr, rxv, done;
    logic [7:0] rxd;
  } ent_t;
  ent_t exp_q[$];
  logic m_last = 1'b0;
  logic pend = 1'b0;
  logic [7:0] pend_d = 8'h00;

  task automatic put(logic c, logic s, logic t, logic d);
    ent_t e;
    e.cs = c; e.sck = s; e.mosi = m_last; e.txr = t; e.done = d;
    e.rxv = pend; e.rxd = pend ? pend_d : 8'h00;
    pend = 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic build(bit pause_after);
    logic act = cs_active_high;
    int tb0 = txi;
    int sb0 = gbi / 8;
    int k = 0;
    int fh = cpol ? int'(sck_hi_cyc) : int'(sck_lo_cyc);
    int sh = cpol ? int'(sck_lo_cyc) : int'(sck_hi_cyc);
    exp_q.delete();
    pend = 1'b0;
    for (int p = 0; p <= int'(pkt_count_m1); p++) begin
      repeat (int'(cs_setup_cyc) + 1) put(act, cpol, 1'b0, 1'b0);
      for (int b = 0; b <= int'(pkt_bytes_m1); b++) begin
        logic [7:0] t = txb(tb0 + k);
        logic [7:0] r = sbb(sb0 + k);
        repeat (stall_of(tb0 + k) + 1) put(act, cpol, 1'b1, 1'b0);
        for (int j = 0; j < 8; j++) begin
          logic bv = tx_lsb_first ? t[j] : t[7-j];
          if (!cpha) m_last = bv;
          repeat (fh + 1) put(act, cpol, 1'b0, 1'b0);
          if (cpha) m_last = bv;
          repeat (sh + 1) put(act, ~cpol, 1'b0, 1'b0);
        end
        pend = 1'b1;
        pend_d = rx_lsb_first ? rev8(r) : r;
        k++;
      end
      repeat (int'(cs_hold_cyc) + 1) put(act, cpol, 1'b0, 1'b0);
      if (p < int'(pkt_count_m1)) repeat (int'(cs_gap_cyc) + 1) put(~act, cpol, 1'b0, 1'b0);
    end
    put(pause_after ? act : ~act, cpol, 1'b0, 1'b1);
  endtask

  task automatic compare(int i);
    ent_t e = exp_q[i];
    string tag;
    n_cmp++;
    tag = "";
    if (spi_cs !== e.cs) tag = "R6/R2/R10 cs";
    else if (spi_sck !== e.sck) tag = "R3 sck";
    else if (spi_mosi !== e.mosi) tag = "R4/R5 mosi";
    else if (tx_ready !== e.txr) tag = "R8 tx_ready";
    else if (rx_valid !== e.rxv) tag = "R9 rx_valid";
    else if (e.rxv && rx_data !== e.rxd) tag = "R5/R4 rx_data";
    else if (done !== e.done) tag = "R7 done";
    if (tag != "") begin
      n_bad++;
      $display("FAIL %s entry %0d: actual cs=%b sck=%b mosi=%b txr=%b rxv=%b rxd=%h done=%b expected cs=%b sck=%b mosi=%b txr=%b rxv=%b rxd=%h done=%b",
               tag, i, spi_cs, spi_sck, spi_mosi, tx_ready, rx_valid, rx_data, done,
               e.cs, e.sck, e.mosi, e.txr, e.rxv, e.rxd, e.done);
    end
  endtask

  task automatic check1(string tag, logic [7:0] act_v, logic [7:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  // Runs one case; mid_start pulses start inside the run (R13); abort_at aborts (R12)
  task automatic run_case(bit via_resume, bit pause_after, int mid_start, int abort_at);
    build(pause_after);
    @(negedge clk);
    if (via_resume) resume = 1'b1; else start = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      start = 1'b0; resume = 1'b0;
      compare(i);
      if (i == mid_start) start = 1'b1;
      if (i == abort_at) begin
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        m_last = 1'b0;
        // R12: idle outputs on the cycle after abort
        check1("R12 cs after abort", {7'd0, spi_cs}, {7'd0, ~cs_active_high});
        check1("R12 sck/mosi/tx_ready after abort", {5'd0, spi_sck, spi_mosi, tx_ready}, {5'd0, cpol, 1'b0, 1'b0});
        return;
      end
    end
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check1("R1 cs/sck/mosi", {5'd0, spi_cs, spi_sck, spi_mosi}, {5'd0, 1'b1, 1'b0, 1'b0});
    check1("R1 tx_ready/rx_valid/done", {5'd0, tx_ready, rx_valid, done}, 8'd0);

    // R2 R3 R4 R6 R7 R13: mode 0, two packets of three bytes, start pulsed mid-run
    sck_hi_cyc = 8'd1; sck_lo_cyc = 8'd2; cs_setup_cyc = 16'd2; cs_hold_cyc = 16'd1;
    cs_gap_cyc = 8'd3; pkt_bytes_m1 = 16'd2; pkt_count_m1 = 8'd1;
    idle_wait(3);
    run_case(1'b0, 1'b0, 30, -1);
    idle_wait(4);

    // R10 R5 R3: mode 3, LSB-first transmit, active-high select, minimal counts
    cpol = 1'b1; cpha = 1'b1; tx_lsb_first = 1'b1; rx_lsb_first = 1'b0; cs_active_high = 1'b1;
    sck_hi_cyc = 8'd0; sck_lo_cyc = 8'd0; cs_setup_cyc = 16'd0; cs_hold_cyc = 16'd0;
    cs_gap_cyc = 8'd0; pkt_bytes_m1 = 16'd1; pkt_count_m1 = 8'd2;
    idle_wait(3);
    run_case(1'b0, 1'b0, -1, -1);
    idle_wait(4);

    // R8 R5 R4: mode 1, LSB-first receive, transmit bytes withheld for a few cycles
    cpol = 1'b0; cpha = 1'b1; tx_lsb_first = 1'b0; rx_lsb_first = 1'b1; cs_active_high = 1'b0;
    sck_hi_cyc = 8'd2; sck_lo_cyc = 8'd0; cs_setup_cyc = 16'd0; cs_hold_cyc = 16'd3;
    pkt_bytes_m1 = 16'd3; pkt_count_m1 = 8'd0; stall_on = 1'b1;
    idle_wait(3);
    run_case(1'b0, 1'b0, -1, -1);
    stall_on = 1'b0;
    idle_wait(4);

    // R11: mode 2 with pause, then resume
    cpol = 1'b1; cpha = 1'b0; rx_lsb_first = 1'b0; pause_en = 1'b1;
    sck_hi_cyc = 8'd0; sck_lo_cyc = 8'd1; cs_setup_cyc = 16'd1; cs_hold_cyc = 16'd0;
    cs_gap_cyc = 8'd2; pkt_bytes_m1 = 16'd0; pkt_count_m1 = 8'd1;
    idle_wait(3);
    run_case(1'b0, 1'b1, -1, -1);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      // R11: select held, bus quiet while paused
      check1("R11 paused outputs", {4'd0, spi_cs, spi_sck, done, tx_ready}, {4'd0, 1'b0, 1'b1, 1'b0, 1'b0});
    end
    pause_en = 1'b0;
    run_case(1'b1, 1'b0, -1, -1);
    idle_wait(4);

    // R12: abort during the bit phase, then a clean run
    cpol = 1'b0; cpha = 1'b0;
    sck_hi_cyc = 8'd1; sck_lo_cyc = 8'd2; cs_setup_cyc = 16'd2; cs_hold_cyc = 16'd1;
    cs_gap_cyc = 8'd3; pkt_bytes_m1 = 16'd2; pkt_count_m1 = 8'd1;
    idle_wait(3);
    run_case(1'b0, 1'b0, -1, 25);
    idle_wait(4);
    run_case(1'b0, 1'b0, -1, -1);
    idle_wait(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule